// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is a management-interface master for an Ethernet PHY. A host loads three registers (a data word, a 16-bit register address and an operation word) and then writes 1 to a control register. The block then sends one complete 64-bit management frame on the MDC/MDIO pair. Each frame is a preamble, start, opcode, port address, device/register field, turnaround and 16 data bits. On read operations it releases the data line at the turnaround and shifts in the 16 bits the PHY returns. At the end of the frame it places those bits in the data register.

Clause 22 and Clause 45 framing share one shift engine. A bit in the operation word picks the clause for each frame. A Clause 22 access needs a single frame. A Clause 45 access is issued by the host as two frames: an address frame that carries the address register, followed by a write or read frame. MDC comes from the system clock through a divider whose half period is the parameter `MDC_HALF`.

Top module: `mdio_master`

## Requirements
- R1: After reset all host registers read 0, the control register reads 0, MDC is low and the MDIO output enable is low. MDC and the output enable stay low whenever no frame is in progress.
- R2: Writing a word with bit 0 set to host register 3 starts a frame, and register 3 then reads 1. It returns to 0 exactly 64 × 2 × `MDC_HALF` clock cycles after the start write.
- R3: A start write that arrives while a frame is in progress is ignored. The running frame's bits and its completion time do not change, even if the operation register is rewritten first.
- R4: Every frame begins with 32 consecutive MDIO bits of value 1.
- R5: Host register 2 is the operation word, laid out as follows: bit 12 selects the clause (0 = Clause 22, 1 = Clause 45); bits 11:10 are the opcode; bits 9:5 are the port address; bits 4:0 are the Clause 22 register number or the Clause 45 device. A Clause 22 frame carries start 01, followed by opcode, port and register number, each sent MSB first.
- R6: A Clause 45 frame carries start 00. With opcode 00 (address) it sends turnaround 10 followed by the value of host register 1, the address register.
- R7: For write opcodes (Clause 22 01, Clause 45 01) the frame sends turnaround 10 followed by host register 0 as it was at the start. MDIO stays driven for all 64 bits.
- R8: For read opcodes (Clause 22 10, Clause 45 11) the output enable drops for bits 46 to 63. The 16 bits sampled on the rising MDC edges of bits 48 to 63 are assembled MSB first. When the frame ends, they replace host register 0.
- R9: While a frame runs, each MDC period is 2 × `MDC_HALF` clocks: low for the first half, high for the second. MDIO and its enable change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_wsel | input | 2 | Write register select: 0 data, 1 address, 2 operation, 3 control |
| host_wdata | input | 16 | Register write data |
| host_rsel | input | 2 | Read register select, same coding as host_wsel |
| host_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Faults in this block surface at the ports, and each kind shows up at a different point in the frame:
- A wrong shift position or latched operation appears as a wrong bit on MDIO, and the bench compares every bit of every frame on the rising MDC edge.
- A bit counter that is off, or a start that restarts a frame, moves the fall of the busy bit away from the 256-cycle point, and the bench counts that to the cycle.
- A wrong sampling edge or turnaround window corrupts the read value that appears in the data register when busy clears. It can also leave the output enable high over bits the PHY drives.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef struct packed {
    logic       c45;
    logic [1:0] opc;
    logic [4:0] port;
    logic [4:0] dev;
  } mdio_op_t;

  // read opcodes: clause 45 uses 11, clause 22 uses 10
  function automatic logic op_is_read(mdio_op_t o);
    return o.c45 ? (o.opc == 2'b11) : (o.opc == 2'b10);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_op_t o, logic [15:0] addr,
                                                         logic [15:0] wdat);
    logic [15:0] payload;
    logic [1:0]  ta;
    logic [1:0]  st;
    payload = (o.c45 && o.opc == 2'b00) ? addr : wdat;
    ta      = op_is_read(o) ? 2'b11 : 2'b10;
    st      = o.c45 ? 2'b00 : 2'b01;
    return {32'hFFFF_FFFF, st, o.opc, o.port, o.dev, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic end_tk
);
  localparam int PER = 2 * HALF;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run)                    cnt <= '0;
    else if (cnt == CW'(PER - 1))     cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign mdc     = run && (cnt >= CW'(HALF));
  assign rise_tk = run && (cnt == CW'(HALF));
  assign end_tk  = run && (cnt == CW'(PER - 1));

  // R9
  mdc_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(run));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_in,
  input  logic                  bit_rise,
  input  logic                  bit_end,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  cur_rd,
  output logic [5:0]            bit_idx,
  output logic                  last_bit,
  output logic                  done,
  output logic [15:0]           rd_word,
  output logic                  mdio_o,
  output logic                  mdio_oe
);
  logic [FRAME_BITS-1:0] sh;
  logic [15:0]           rd_sh;

  assign last_bit = (bit_idx == 6'(FRAME_BITS - 1));
  assign done     = busy && bit_end && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_rd  <= 1'b0;
      bit_idx <= '0;
      sh      <= '0;
      rd_sh   <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      cur_rd  <= rd_in;
      bit_idx <= '0;
      sh      <= frame_in;
    end else if (busy) begin
      if (bit_rise && cur_rd && bit_idx >= 6'(DATA_POS))
        rd_sh <= {rd_sh[14:0], mdio_i};
      if (bit_end) begin
        sh <= sh << 1;
        if (last_bit) begin
          busy    <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  assign rd_word = rd_sh;
  assign mdio_o  = sh[FRAME_BITS-1];
  assign mdio_oe = busy && !(cur_rd && bit_idx >= 6'(TA_POS));

  // R4
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < 6'd32) |-> mdio_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_wsel,
  input  logic [15:0] host_wdata,
  input  logic [1:0]  host_rsel,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [15:0] data_q, addr_q, op_q;
  logic        busy, cur_rd, last_bit, done, rise_tk, end_tk;
  logic [5:0]  bit_idx;
  logic [15:0] rd_word;
  logic        go_req, load;
  mdio_op_t    op_s;

  assign op_s   = mdio_op_t'(op_q[12:0]);
  assign go_req = host_we && (host_wsel == 2'd3) && host_wdata[0];
  assign load   = go_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      addr_q <= '0;
      op_q   <= '0;
    end else begin
      if (done && cur_rd)                          data_q <= rd_word;
      else if (host_we && host_wsel == 2'd0)       data_q <= host_wdata;
      if (host_we && host_wsel == 2'd1)            addr_q <= host_wdata;
      if (host_we && host_wsel == 2'd2)            op_q   <= host_wdata;
    end
  end

  always_comb begin
    case (host_rsel)
      2'd0:    host_rdata = data_q;
      2'd1:    host_rdata = addr_q;
      2'd2:    host_rdata = op_q;
      default: host_rdata = {15'd0, busy};
    endcase
  end

  mdio_clkgen #(.HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tk(rise_tk), .end_tk(end_tk)
  );

  mdio_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .load(load),
    .frame_in(build_frame(op_s, addr_q, data_q)), .rd_in(op_is_read(op_s)),
    .bit_rise(rise_tk), .bit_end(end_tk), .mdio_i(mdio_i),
    .busy(busy), .cur_rd(cur_rd), .bit_idx(bit_idx), .last_bit(last_bit),
    .done(done), .rd_word(rd_word), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_bit && end_tk));

  // R3
  ignore_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req && bit_idx != 6'd0 && !last_bit) |=> (busy && bit_idx != 6'd0));

  // R9
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 64 * 2 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_wsel = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_rsel = 2'd3;
  logic [15:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  logic [63:0] cap_o, cap_oe;
  int          npos;
  logic [15:0] resp;
  time         t_prev, period;

  always #2 clk = ~clk;

  mdio_master #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wsel(host_wsel),
    .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side observer and responder
  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    period = $time - t_prev;
    t_prev = $time;
    npos   = npos + 1;
  end
  always @(negedge mdc) begin
    if (npos >= 48 && npos <= 63) mdio_i = resp[63 - npos];
    else                          mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] opc,
      input logic [4:0] port, input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] d);
    exp_frame = {{32{1'b1}}, (c45 ? 2'b00 : 2'b01), opc, port, dev, ta, d};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1; host_wsel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    host_rsel = sel;
    #1 v = host_rdata;
    host_rsel = 2'd3;
  endtask

  // start a frame; optionally inject an op rewrite and a second start at cycle inj
  task automatic run_frame(input int inj, input logic [15:0] inj_op, output int cyc);
    npos = 0; cap_o = '0; cap_oe = '0;
    @(negedge clk);
    host_rsel = 2'd3;
    host_we = 1'b1; host_wsel = 2'd3; host_wdata = 16'h0001;
    @(negedge clk);
    host_we = 1'b0;
    cyc = 0;
    while (host_rdata[0] === 1'b1 && cyc < 2 * FRAME_CYC) begin
      cyc++;
      if (cyc == inj)     begin host_we = 1'b1; host_wsel = 2'd2; host_wdata = inj_op; end
      if (cyc == inj + 1) begin host_wsel = 2'd3; host_wdata = 16'h0001; end
      if (cyc == inj + 2) host_we = 1'b0;
      @(negedge clk);
    end
    host_we = 1'b0;
  endtask

  function automatic logic [15:0] opw(input logic c45, input logic [1:0] opc,
                                      input logic [4:0] port, input logic [4:0] dev);
    opw = {3'b000, c45, opc, port, dev};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 data", 64'(v), 64'h0);
    rd(2'd1, v); chk("R1 addr", 64'(v), 64'h0);
    rd(2'd2, v); chk("R1 op", 64'(v), 64'h0);
    rd(2'd3, v); chk("R1 ctl", 64'(v), 64'h0);
    chk("R1 mdc/oe idle", {62'd0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_c22_write();
    int c;
    wr(2'd0, 16'hA5C3);
    wr(2'd2, opw(1'b0, 2'b01, 5'h11, 5'h1B));
    run_frame(-10, 16'h0, c);
    chk("R2 frame length", 64'(c), 64'(FRAME_CYC));
    chk("R5 R7 c22 write bits", cap_o, exp_frame(1'b0, 2'b01, 5'h11, 5'h1B, 2'b10, 16'hA5C3));
    chk("R4 preamble", {32'd0, cap_o[63:32]}, 64'hFFFF_FFFF);
    chk("R7 oe whole frame", cap_oe, {64{1'b1}});
    chk("R9 mdc period", 64'(period), 64'(2 * HALF * 4));
    chk("R1 R9 mdc low after", {63'd0, mdc}, 64'h0);
  endtask

  task automatic t_c45_addr();
    int c;
    wr(2'd1, 16'h9002);
    wr(2'd0, 16'h1111);
    wr(2'd2, opw(1'b1, 2'b00, 5'h05, 5'h01));
    run_frame(-10, 16'h0, c);
    chk("R6 c45 address bits", cap_o, exp_frame(1'b1, 2'b00, 5'h05, 5'h01, 2'b10, 16'h9002));
    chk("R2 c45 length", 64'(c), 64'(FRAME_CYC));
  endtask

  task automatic t_c45_write();
    int c;
    wr(2'd0, 16'h8040);
    wr(2'd2, opw(1'b1, 2'b01, 5'h1F, 5'h03));
    run_frame(-10, 16'h0, c);
    chk("R7 c45 write bits", cap_o, exp_frame(1'b1, 2'b01, 5'h1F, 5'h03, 2'b10, 16'h8040));
    chk("R7 c45 write oe", cap_oe, {64{1'b1}});
  endtask

  task automatic t_read(input logic c45, input logic [1:0] opc, input logic [15:0] r, input string tag);
    int c;
    logic [15:0] v;
    logic [63:0] e;
    resp = r;
    wr(2'd0, 16'h0000);
    wr(2'd2, opw(c45, opc, 5'h0A, 5'h07));
    run_frame(-10, 16'h0, c);
    e = exp_frame(c45, opc, 5'h0A, 5'h07, 2'b11, 16'h0);
    chk({"R8 header ", tag}, {18'd0, cap_o[63:18]}, {18'd0, e[63:18]});
    chk({"R8 release ", tag}, cap_oe, {{46{1'b1}}, 18'd0});
    rd(2'd0, v);
    chk({"R8 read data ", tag}, 64'(v), 64'(r));
  endtask

  task automatic t_busy_ignore();
    int c;
    wr(2'd0, 16'h3C3C);
    wr(2'd2, opw(1'b0, 2'b01, 5'h02, 5'h04));
    run_frame(60, opw(1'b1, 2'b11, 5'h1E, 5'h1D), c);
    chk("R3 length unchanged", 64'(c), 64'(FRAME_CYC));
    chk("R3 frame unchanged", cap_o, exp_frame(1'b0, 2'b01, 5'h02, 5'h04, 2'b10, 16'h3C3C));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    npos = 0; t_prev = 0; period = 0; resp = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c45_addr();
    t_c45_write();
    t_read(1'b1, 2'b11, 16'hBEEF, "c45");
    t_read(1'b0, 2'b10, 16'h4812, "c22");
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule